// File: doc/BRIEF.md
# DMA channel maintenance controller

This block is the control core of one DMA channel. Bytes arrive from a peripheral-side read port, wait in a small FIFO, and leave through a memory-side write port. Both ports use a valid/ready handshake, and one byte moves per handshake. Software steers the channel with one-cycle command pulses:

- enable
- disable
- read suspend
- write suspend
- combined read-write suspend
- resume
- flush

The block settles how each command interacts with the transfers in flight and with any earlier command that is still pending.

A configuration input says whether the channel is synchronised to a source peripheral. On such a channel a disable first drains the FIFO to memory. On other channels a disable stops all traffic once the write beat in progress completes. The block reports:

- a channel-active bit;
- the suspend state;
- the FIFO byte count;
- two sticky completion flags, one for disable and one for flush. Both are cleared by one clear pulse.

Top module: `dma_chan_maint`

## Requirements
- R1: After reset the channel is inactive. Both flags are 0, the byte count is 0, and neither rdReady nor wrValid is high, even with rdValid high.
- R2: After an enable pulse the channel is active, reads are accepted, and bytes leave on the write port in the order they were read, one byte per handshake.
- R3: A read-suspend pulse drops rdReady from the next cycle, and rdSuspended reads 1. Writes keep draining the FIFO. A resume pulse restores rdReady.
- R4: A write-suspend pulse stops new write beats from the next cycle. Reads continue until the count reaches DEPTH (8), and then rdReady stays low. The FIFO contents are kept, and resume restarts the writes.
- R5: A read-write suspend pulse stops both ports and holds the byte count constant until resume.
- R6: A flush pulse writes out every byte held at that moment, even while writes are suspended. flushDone rises in the cycle after the last of those bytes is accepted. A flush on an empty FIFO sets flushDone one cycle after the pulse.
- R7: On a source-synchronised channel, a disable pulse clears the write-suspend bit and stops reads. It drains every FIFO byte to memory and then sets disDone and drops chanActive, with the count at 0.
- R8: On a channel that is not source-synchronised, a disable pulse starts no new beat. A write already presented stays valid until it is accepted. In the cycle after that acceptance, disDone is 1, chanActive is 0, and any remaining FIFO bytes are discarded (count 0).
- R9: A disable that arrives while a flush still has more than one byte to write, or whose last byte is not yet presented, abandons the flush, and flushDone never rises. If the last flush byte is already presented, both flags rise together once it is accepted.
- R10: A flush or write-suspend pulse that arrives after a disable has been accepted is ignored. wrSuspended stays 0 and flushDone is not set.
- R11: Both flags are sticky until a flagClear pulse clears them. When disable arrives in the same cycle as other commands, the disable alone takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcPerSync | input | 1 | 1: channel synchronised to a source peripheral (drain on disable) |
| cmdEnable | input | 1 | Pulse: activate an idle channel, clearing both suspend bits |
| cmdDisable | input | 1 | Pulse: disable request |
| cmdRdSuspend | input | 1 | Pulse: suspend reads |
| cmdWrSuspend | input | 1 | Pulse: suspend writes |
| cmdRwSuspend | input | 1 | Pulse: suspend both reads and writes |
| cmdResume | input | 1 | Pulse: clear both suspend bits |
| cmdFlush | input | 1 | Pulse: write the FIFO contents out |
| flagClear | input | 1 | Pulse: clear disDone and flushDone |
| rdValid | input | 1 | Peripheral byte offered |
| rdData | input | WIDTH | Peripheral byte |
| rdReady | output | 1 | Channel accepts a peripheral byte |
| wrValid | output | 1 | Channel offers a byte to memory |
| wrData | output | WIDTH | Byte to memory |
| wrReady | input | 1 | Memory accepts the byte |
| fifoCount | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| chanActive | output | 1 | Channel active |
| rdSuspended | output | 1 | Read-suspend bit |
| wrSuspended | output | 1 | Write-suspend bit |
| disDone | output | 1 | Sticky end-of-disable flag |
| flushDone | output | 1 | Sticky end-of-flush flag |

## Verification
A disable and the last write of a flush can fall in the same cycle. Two tests separate the outcomes:

- The bench holds wrReady low, so flush beats stay presented, and steps exactly seven of the eight flush bytes through. It then pulses disable while the final byte waits. Both flags must rise in the single cycle after that byte is accepted.
- A twin test pulses disable while all eight bytes are still pending. It expects disDone alone.

A third test drives disable, flush and both suspends in one cycle. It judges the result by the suspend bits and flags seen at the ports.

// File: rtl/dma_maint_pkg.sv
package dma_maint_pkg;
  // strobes from control to the FIFO datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } fifo_ctl_t;
endpackage

// File: rtl/dma_maint_fifo.sv
module dma_maint_fifo
  import dma_maint_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_ctl_t        ctl,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] outData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (ctl.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      cnt <= cnt + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.push && !ctl.clr) mem[wrPtr] <= inData;
  end

  assign outData = mem[rdPtr];
  assign count   = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/dma_maint_ctrl.sv
module dma_maint_ctrl
  import dma_maint_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcPerSync,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             cmdRdSuspend,
  input  logic             cmdWrSuspend,
  input  logic             cmdRwSuspend,
  input  logic             cmdResume,
  input  logic             cmdFlush,
  input  logic             flagClear,
  input  logic             rdValid,
  input  logic             wrReady,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  input  logic             full,
  output logic             rdReady,
  output logic             wrValid,
  output fifo_ctl_t        ctl,
  output logic             chanActive,
  output logic             rdSuspended,
  output logic             wrSuspended,
  output logic             disDone,
  output logic             flushDone
);
  logic activeQ, disablingQ, rdSuspQ, wrSuspQ, flushingQ, pendQ;
  logic disDoneQ, flushDoneQ;
  logic [CNT_W-1:0] remainQ;

  logic push, pop, allowNew, accept, disCmd, otherOk, enCmd;
  logic finalSched, disFinish;
  logic [CNT_W-1:0] flushLeft;

  always_comb begin
    accept   = activeQ && !disablingQ;
    disCmd   = cmdDisable && accept;
    otherOk  = accept && !cmdDisable;          // disable wins a same-cycle tie
    enCmd    = cmdEnable && !activeQ && !cmdDisable;
    allowNew = flushingQ || (disablingQ ? srcPerSync : !wrSuspQ);
    rdReady  = activeQ && !disablingQ && !rdSuspQ && !full;
    wrValid  = activeQ && !empty && (pendQ || allowNew);
    push     = rdValid && rdReady;
    pop      = wrValid && wrReady;
    finalSched = flushingQ && (remainQ == CNT_W'(1)) && wrValid;
    disFinish  = disablingQ && (srcPerSync ? empty : (!wrValid || wrReady));
    flushLeft  = count - CNT_W'(pop);
    ctl.push = push;
    ctl.pop  = pop;
    ctl.clr  = disFinish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ    <= 1'b0;
      disablingQ <= 1'b0;
      rdSuspQ    <= 1'b0;
      wrSuspQ    <= 1'b0;
      flushingQ  <= 1'b0;
      pendQ      <= 1'b0;
      disDoneQ   <= 1'b0;
      flushDoneQ <= 1'b0;
      remainQ    <= '0;
    end else begin
      pendQ <= wrValid && !wrReady;
      if (flagClear) begin
        disDoneQ   <= 1'b0;
        flushDoneQ <= 1'b0;
      end
      if (flushingQ && pop) begin
        remainQ <= remainQ - 1'b1;
        if (remainQ == CNT_W'(1)) begin
          flushingQ  <= 1'b0;
          flushDoneQ <= 1'b1;
        end
      end
      if (otherOk) begin
        if (cmdResume) begin
          rdSuspQ <= 1'b0;
          wrSuspQ <= 1'b0;
        end
        if (cmdRdSuspend || cmdRwSuspend) rdSuspQ <= 1'b1;
        if (cmdWrSuspend || cmdRwSuspend) wrSuspQ <= 1'b1;
        if (cmdFlush && !flushingQ) begin
          if (flushLeft == '0) flushDoneQ <= 1'b1;
          else begin
            flushingQ <= 1'b1;
            remainQ   <= flushLeft;
          end
        end
      end
      if (disCmd) begin
        disablingQ <= 1'b1;
        wrSuspQ    <= 1'b0;
        if (!finalSched) flushingQ <= 1'b0;
      end
      if (disFinish) begin
        activeQ    <= 1'b0;
        disablingQ <= 1'b0;
        disDoneQ   <= 1'b1;
      end
      if (enCmd) begin
        activeQ <= 1'b1;
        rdSuspQ <= 1'b0;
        wrSuspQ <= 1'b0;
      end
    end
  end

  assign chanActive  = activeQ;
  assign rdSuspended = rdSuspQ;
  assign wrSuspended = wrSuspQ;
  assign disDone     = disDoneQ;
  assign flushDone   = flushDoneQ;
endmodule

// File: rtl/dma_chan_maint.sv
module dma_chan_maint
  import dma_maint_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcPerSync,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             cmdRdSuspend,
  input  logic             cmdWrSuspend,
  input  logic             cmdRwSuspend,
  input  logic             cmdResume,
  input  logic             cmdFlush,
  input  logic             flagClear,
  input  logic             rdValid,
  input  logic [WIDTH-1:0] rdData,
  output logic             rdReady,
  output logic             wrValid,
  output logic [WIDTH-1:0] wrData,
  input  logic             wrReady,
  output logic [CNT_W-1:0] fifoCount,
  output logic             chanActive,
  output logic             rdSuspended,
  output logic             wrSuspended,
  output logic             disDone,
  output logic             flushDone
);
  fifo_ctl_t fifoCtl;
  logic      fifoEmpty, fifoFull;

  dma_maint_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcPerSync(srcPerSync),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .cmdRdSuspend(cmdRdSuspend), .cmdWrSuspend(cmdWrSuspend),
    .cmdRwSuspend(cmdRwSuspend), .cmdResume(cmdResume),
    .cmdFlush(cmdFlush), .flagClear(flagClear),
    .rdValid(rdValid), .wrReady(wrReady),
    .count(fifoCount), .empty(fifoEmpty), .full(fifoFull),
    .rdReady(rdReady), .wrValid(wrValid), .ctl(fifoCtl),
    .chanActive(chanActive), .rdSuspended(rdSuspended),
    .wrSuspended(wrSuspended), .disDone(disDone), .flushDone(flushDone)
  );

  dma_maint_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rstN(rstN), .ctl(fifoCtl), .inData(rdData),
    .outData(wrData), .count(fifoCount), .empty(fifoEmpty), .full(fifoFull)
  );
endmodule

// File: rtl/dma_chan_maint_chk.sv
module dma_chan_maint_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReady,
  input logic             wrValid,
  input logic [WIDTH-1:0] wrData,
  input logic             wrReady,
  input logic [CNT_W-1:0] fifoCount,
  input logic             chanActive,
  input logic             rdSuspended,
  input logic             disDone,
  input logic             flushDone,
  input logic             flagClear
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));
  assert_full_blocks_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !rdReady);
  assert_empty_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> !wrValid);
  assert_rd_suspend_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdSuspended |-> !rdReady);
  assert_write_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive |-> (!rdReady && !wrValid));
  assert_dis_ends_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disDone) |-> !chanActive);
  assert_dis_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (disDone && !flagClear) |=> disDone);
  assert_flush_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flushDone && !flagClear) |=> flushDone);
endmodule

bind dma_chan_maint dma_chan_maint_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .rdReady(rdReady), .wrValid(wrValid),
  .wrData(wrData), .wrReady(wrReady), .fifoCount(fifoCount),
  .chanActive(chanActive), .rdSuspended(rdSuspended),
  .disDone(disDone), .flushDone(flushDone), .flagClear(flagClear)
);

// File: tb/dma_chan_maint_tb.sv
module dma_chan_maint_tb;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, srcPerSync = 1'b1;
  logic cmdEnable = 0, cmdDisable = 0, cmdRdSuspend = 0, cmdWrSuspend = 0;
  logic cmdRwSuspend = 0, cmdResume = 0, cmdFlush = 0, flagClear = 0;
  logic rdValid = 0, wrReady = 0;
  logic [WIDTH-1:0] rdData, wrData;
  logic rdReady, wrValid, chanActive, rdSuspended, wrSuspended, disDone, flushDone;
  logic [CNT_W-1:0] fifoCount;

  int checks = 0, errors = 0, wrCnt = 0;
  logic [WIDTH-1:0] srcByte = '0, expByte = '0;
  bit finished = 0;
  assign rdData = srcByte;

  dma_chan_maint #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // port monitor: sample just before the edge, update just after it
  always begin
    logic rf, wf;
    logic [WIDTH-1:0] wd;
    @(negedge clk); #4;
    rf = rdValid && rdReady;
    wf = wrValid && wrReady;
    wd = wrData;
    @(posedge clk); #1;
    if (rf) srcByte = srcByte + 1'b1;
    if (wf) begin
      chk(wd == expByte, "R2 write order", int'(wd), int'(expByte));
      expByte = expByte + 1'b1;
      wrCnt++;
    end
  end

  task automatic enable(input logic sync);
    srcPerSync = sync;
    cmdEnable = 1; tick(); cmdEnable = 0;
  endtask

  task automatic clearFlags();
    flagClear = 1; tick(); flagClear = 0;
  endtask

  task automatic fillSuspended();
    wrReady = 1; rdValid = 1;
    cmdWrSuspend = 1; tick(); cmdWrSuspend = 0;
    for (int i = 0; i < 30 && fifoCount != CNT_W'(DEPTH); i++) tick();
    rdValid = 0;
  endtask

  task automatic waitDis();
    for (int i = 0; i < 40 && !disDone; i++) tick();
  endtask

  task automatic testReset();
    rdValid = 1;
    tick();
    chkEq("R1 active", chanActive, 0);
    chkEq("R1 rdReady", rdReady, 0);
    chkEq("R1 wrValid", wrValid, 0);
    chkEq("R1 flags", {disDone, flushDone}, 0);
    chkEq("R1 count", fifoCount, 0);
    rdValid = 0;
  endtask

  task automatic testStream();
    int start;
    enable(1'b1);
    chkEq("R2 active", chanActive, 1);
    start = wrCnt;
    rdValid = 1; wrReady = 1;
    tick(20);
    chk(wrCnt - start >= 15, "R2 throughput", wrCnt - start, 15);
  endtask

  task automatic testRdSuspend();
    cmdRdSuspend = 1; tick(); cmdRdSuspend = 0;
    chkEq("R3 rdSuspended", rdSuspended, 1);
    chkEq("R3 rdReady low", rdReady, 0);
    tick(3);
    chkEq("R3 writes drained", fifoCount, 0);
    cmdResume = 1; tick(); cmdResume = 0;
    chkEq("R3 resumed", rdReady, 1);
  endtask

  task automatic testWrSuspend();
    int w;
    cmdWrSuspend = 1; tick(); cmdWrSuspend = 0;
    chkEq("R4 wrValid low", wrValid, 0);
    w = wrCnt;
    tick(12);
    chkEq("R4 fifo full", fifoCount, DEPTH);
    chkEq("R4 reads stop when full", rdReady, 0);
    chkEq("R4 no writes", wrCnt - w, 0);
    cmdResume = 1; tick(); cmdResume = 0;
    tick();
    chkEq("R4 writes resume", wrValid, 1);
  endtask

  task automatic testRwSuspend();
    int c, w;
    cmdRwSuspend = 1; tick(); cmdRwSuspend = 0;
    c = fifoCount; w = wrCnt;
    tick(4);
    chkEq("R5 count held", fifoCount, c);
    chkEq("R5 no writes", wrCnt - w, 0);
    chkEq("R5 ports idle", {rdReady, wrValid}, 0);
    cmdResume = 1; tick(); cmdResume = 0;
  endtask

  task automatic testFlush();
    int start;
    fillSuspended();
    clearFlags();
    start = wrCnt;
    cmdFlush = 1; tick(); cmdFlush = 0;
    for (int i = 0; i < 20 && !flushDone; i++) tick();
    chkEq("R6 flush flag", flushDone, 1);
    chkEq("R6 bytes flushed", wrCnt - start, DEPTH);
    chkEq("R6 suspend kept", wrSuspended, 1);
    clearFlags();
    chkEq("R11 flag cleared", flushDone, 0);
    cmdFlush = 1; tick(); cmdFlush = 0;
    chkEq("R6 empty flush flag", flushDone, 1);
    cmdResume = 1; tick(); cmdResume = 0;
  endtask

  task automatic testDisableSync();
    int start;
    fillSuspended();
    clearFlags();
    start = wrCnt;
    rdValid = 1;
    cmdDisable = 1; tick(); cmdDisable = 0;
    chkEq("R7 write suspend cleared", wrSuspended, 0);
    chkEq("R7 reads stopped", rdReady, 0);
    waitDis();
    chkEq("R7 disDone", disDone, 1);
    chkEq("R7 drained", wrCnt - start, DEPTH);
    chkEq("R7 inactive", chanActive, 0);
    chkEq("R7 count", fifoCount, 0);
    rdValid = 0;
    tick(3);
    chkEq("R11 sticky", disDone, 1);
    clearFlags();
    chkEq("R11 cleared", disDone, 0);
  endtask

  task automatic testDisableAsync();
    int start;
    enable(1'b0);
    rdValid = 1; wrReady = 0;
    tick(4);
    chkEq("R8 write pending", wrValid, 1);
    cmdDisable = 1; tick(); cmdDisable = 0;
    rdValid = 0;
    chkEq("R8 no reads", rdReady, 0);
    chkEq("R8 pending held", wrValid, 1);
    chkEq("R8 not done yet", disDone, 0);
    start = wrCnt;
    wrReady = 1; tick();
    chkEq("R8 one beat finished", wrCnt - start, 1);
    chkEq("R8 disDone", disDone, 1);
    chkEq("R8 inactive", chanActive, 0);
    chkEq("R8 discarded", fifoCount, 0);
    expByte = srcByte;                 // leftover bytes were discarded
    clearFlags();
  endtask

  task automatic testFlushAbandon();
    int start;
    enable(1'b1);
    fillSuspended();
    wrReady = 0;
    clearFlags();
    cmdFlush = 1; tick(); cmdFlush = 0;
    cmdDisable = 1; tick(); cmdDisable = 0;
    start = wrCnt;
    wrReady = 1;
    waitDis();
    chkEq("R9 disDone", disDone, 1);
    chkEq("R9 flush abandoned", flushDone, 0);
    chkEq("R9 drained", wrCnt - start, DEPTH);
    clearFlags();
  endtask

  task automatic testFlushFinal();
    enable(1'b0);
    fillSuspended();
    wrReady = 0;
    clearFlags();
    cmdFlush = 1; tick(); cmdFlush = 0;
    wrReady = 1; tick(DEPTH - 1); wrReady = 0;
    chkEq("R9 last byte left", fifoCount, 1);
    cmdDisable = 1; tick(); cmdDisable = 0;
    chkEq("R9 flags low", {disDone, flushDone}, 0);
    wrReady = 1; tick();
    chkEq("R9 both flags", {disDone, flushDone}, 3);
    chkEq("R9 inactive", chanActive, 0);
    clearFlags();
  endtask

  task automatic testLateCmds();
    enable(1'b1);
    fillSuspended();
    wrReady = 0;
    clearFlags();
    cmdDisable = 1; tick(); cmdDisable = 0;
    cmdFlush = 1; cmdWrSuspend = 1; tick(); cmdFlush = 0; cmdWrSuspend = 0;
    chkEq("R10 suspend ignored", wrSuspended, 0);
    wrReady = 1;
    waitDis();
    chkEq("R10 disDone", disDone, 1);
    chkEq("R10 flush ignored", flushDone, 0);
    clearFlags();
  endtask

  task automatic testSameCycle();
    enable(1'b1);
    rdValid = 1; wrReady = 0;
    tick(3);
    rdValid = 0;
    cmdDisable = 1; cmdFlush = 1; cmdWrSuspend = 1; cmdRdSuspend = 1;
    tick();
    cmdDisable = 0; cmdFlush = 0; cmdWrSuspend = 0; cmdRdSuspend = 0;
    chkEq("R11 suspends dropped", {rdSuspended, wrSuspended}, 0);
    wrReady = 1;
    waitDis();
    chkEq("R11 disable won", disDone, 1);
    chkEq("R11 flush dropped", flushDone, 0);
  endtask

  initial begin
    tick(3);
    rstN = 1;
    testReset();
    testStream();
    testRdSuspend();
    testWrSuspend();
    testRwSuspend();
    testFlush();
    testDisableSync();
    testDisableAsync();
    testFlushAbandon();
    testFlushFinal();
    testLateCmds();
    testSameCycle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule